// File: doc/BRIEF.md
# Paging Address Translation Unit

This unit sits between a processor's address lines and its memories. Each cycle it may take one virtual word address together with a read/write marker and a user/system marker. One cycle later it drives either a physical address or a fault. The page number is looked up in a map with two halves, one for system pages and one for user pages. The offset within the page passes through unchanged. While translation is switched off, the virtual address is passed straight through with zero extension. In both cases the processor sees only a slightly slower memory.

A fault is caused by a missing entry, or by a write to a page that is not writable. A fault records the failing access and raises a store-inhibit level. While that level is high, every later request is refused and the captured restart point is frozen. This lets the processor abandon the instruction with nothing changed and restart it later. The processor moves the eight control words of the unit only as a block: a load reads eight consecutive memory words, and a store writes eight consecutive words. Software fills map entries through a dedicated write port.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, pa_valid, fault, store_inhibit and blk_busy are low, translation is disabled, and a block store returns eight zero words.
- R2: With translation disabled (control slot 0, bit 0 clear), an accepted request yields pa_valid one cycle later with pa equal to the zero-extended virtual address, and no fault.
- R3: With translation enabled, pa one cycle after the request equals the entry's physical page number followed by the low OFS_W bits of the virtual address. The entry is selected by req_user and the upper VA_W-OFS_W address bits.
- R4: System (req_user=0) and user (req_user=1) entries for the same virtual page are independent.
- R5: A request that hits an entry with the valid bit clear gives fault high (not pa_valid) one cycle later. It also sets the fault record in slot 5: bit DATA_W-1 set, bit DATA_W-2 the write marker, bit DATA_W-3 the user marker, the low VA_W bits the virtual address, and the rest zero.
- R6: A write to a valid entry whose write-enable bit is clear faults as in R5. A read of the same entry translates normally.
- R7: While a fault is pending, store_inhibit is high, every request gives fault and never pa_valid, and the fault record keeps the first failing access.
- R8: A pulse on instr_start copies pc_flags into slot 6 unless a fault is pending, in which case slot 6 keeps its value.
- R9: A block load reads blk_base+0 through blk_base+7 on eight consecutive cycles, one read per cycle, with blk_busy high throughout. Word i goes into slot i, except that slot 6 is unchanged and slot 5 is cleared, which ends a pending fault.
- R10: A block store writes slot i to address blk_base+i on eight consecutive cycles, one write per cycle.
- R11: When PA_W is 22, pa bits 15 and 14 are always zero.
- R12: A block start that arrives while a transfer is busy is ignored, and the running transfer ends after its eighth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | VA_W | Virtual word address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request uses the user half of the map |
| pa_valid | output | 1 | Physical address valid (request accepted) |
| pa | output | PA_W | Physical word address |
| fault | output | 1 | Request refused |
| store_inhibit | output | 1 | Fault pending; processor must not store |
| instr_start | input | 1 | Start of an instruction |
| pc_flags | input | DATA_W | PC and flags to capture as restart point |
| map_wr | input | 1 | Write one map entry |
| map_user | input | 1 | Half of the map to write |
| map_vpn | input | VA_W-OFS_W | Virtual page to write |
| map_valid | input | 1 | New entry valid bit |
| map_wen | input | 1 | New entry write-enable bit |
| map_ppn | input | PA_W-OFS_W | New entry physical page number |
| blk_load | input | 1 | Start block load |
| blk_store | input | 1 | Start block store |
| blk_base | input | VA_W | First memory address of the block |
| blk_busy | output | 1 | Block transfer in progress |
| blk_rd | output | 1 | Memory read strobe |
| blk_wr | output | 1 | Memory write strobe |
| blk_addr | output | VA_W | Memory word address of the transfer |
| blk_rdata | input | DATA_W | Word read from memory, same cycle |
| blk_wdata | output | DATA_W | Word to write to memory |

## Verification
The bench builds the unit with an 18-bit virtual address, 1024-word pages and a 22-bit physical address. This turns on the variant with the zeroed bits 15:14, and random page numbers that carry ones in those bits show that the tie holds. All 512 entries of both halves are filled with mixed valid and write-enable patterns. Random requests then cover both halves, and directed ones cover the miss, the read-only write and the refusal while a fault is pending. Block stores bring out the fault record and the frozen restart point through the normal memory path.

// File: rtl/pgu_pkg.sv
package pgu_pkg;
   localparam int SLOT_COUNT   = 8;
   localparam int SLOT_CTL     = 0;
   localparam int SLOT_FAULT   = 5;
   localparam int SLOT_RESTART = 6;
   localparam int CTL_EN_BIT   = 0;

   typedef enum logic [1:0] {
      BLK_IDLE  = 2'd0,
      BLK_LOAD  = 2'd1,
      BLK_STORE = 2'd2
   } blk_state_e;
endpackage

// File: rtl/pgu_map.sv
module pgu_map #(
   parameter int VPN_W = 8,
   parameter int PPN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wr_user,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic             wr_valid,
   input  logic             wr_wen,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             rd_user,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             rd_hit,
   output logic             rd_wen,
   output logic [PPN_W-1:0] rd_ppn
);
   localparam int IDX_W   = VPN_W + 1;
   localparam int ENTRIES = 2 ** IDX_W;

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] wen_q;
   logic [PPN_W-1:0]   ppn_q [ENTRIES];

   logic [IDX_W-1:0] wr_idx, rd_idx;
   assign wr_idx = {wr_user, wr_vpn};
   assign rd_idx = {rd_user, rd_vpn};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         wen_q   <= '0;
      end else if (wr) begin
         valid_q[wr_idx] <= wr_valid;
         wen_q[wr_idx]   <= wr_wen;
      end
   end

   always_ff @(posedge clk) begin
      if (wr) ppn_q[wr_idx] <= wr_ppn;
   end

   assign rd_hit = valid_q[rd_idx];
   assign rd_wen = wen_q[rd_idx];
   assign rd_ppn = ppn_q[rd_idx];
endmodule

// File: rtl/pgu_regs.sv
module pgu_regs
   import pgu_pkg::*;
#(
   parameter int VA_W   = 18,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_load,
   input  logic              blk_store,
   input  logic [VA_W-1:0]   blk_base,
   input  logic [DATA_W-1:0] blk_rdata,
   output logic              blk_busy,
   output logic              blk_rd,
   output logic              blk_wr,
   output logic [VA_W-1:0]   blk_addr,
   output logic [DATA_W-1:0] blk_wdata,
   input  logic              fault_set,
   input  logic              fault_write,
   input  logic              fault_user,
   input  logic [VA_W-1:0]   fault_va,
   input  logic              instr_start,
   input  logic [DATA_W-1:0] pc_flags,
   output logic              xlate_en,
   output logic              fault_pend
);
   localparam int IDX_W = $clog2(SLOT_COUNT);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_COUNT - 1);
   localparam int PAD_W = DATA_W - VA_W - 3;

   blk_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [VA_W-1:0]   base_q;
   logic [DATA_W-1:0] slot_q [SLOT_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= BLK_IDLE;
         idx    <= '0;
         base_q <= '0;
      end else begin
         case (state)
            BLK_IDLE: begin
               idx    <= '0;
               base_q <= blk_base;
               if (blk_load)       state <= BLK_LOAD;
               else if (blk_store) state <= BLK_STORE;
            end
            default: begin
               idx <= idx + 1'b1;
               if (idx == LAST_IDX) state <= BLK_IDLE;
            end
         endcase
      end
   end

   assign blk_busy  = (state != BLK_IDLE);
   assign blk_rd    = (state == BLK_LOAD);
   assign blk_wr    = (state == BLK_STORE);
   assign blk_addr  = base_q + VA_W'(idx);
   assign blk_wdata = slot_q[idx];

   for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
      logic load_hit;
      assign load_hit = blk_rd && (idx == IDX_W'(s));
      if (s == SLOT_FAULT) begin : g_fault
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        slot_q[s] <= '0;
            else if (fault_set) slot_q[s] <= {1'b1, fault_write, fault_user,
                                              {PAD_W{1'b0}}, fault_va};
            else if (load_hit)  slot_q[s] <= '0;
         end
      end else if (s == SLOT_RESTART) begin : g_restart
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         slot_q[s] <= '0;
            else if (instr_start && !fault_pend) slot_q[s] <= pc_flags;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        slot_q[s] <= '0;
            else if (load_hit) slot_q[s] <= blk_rdata;
         end
      end
   end

   assign fault_pend = slot_q[SLOT_FAULT][DATA_W-1];
   assign xlate_en   = slot_q[SLOT_CTL][CTL_EN_BIT];

   // R9 / R10: a transfer reads or writes, never both at once
   a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_rd && blk_wr));
   // R9: consecutive addresses within one transfer
   a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_busy && idx != '0) |-> blk_addr == $past(blk_addr) + 1'b1);
   // R12: a running store is not displaced before its last word
   a_r12_store_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_wr && idx != LAST_IDX) |=> blk_wr);
   // R8: restart point frozen while a fault stays pending
   a_r8_restart_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_pend && $past(fault_pend)) |-> $stable(slot_q[SLOT_RESTART]));
endmodule

// File: rtl/pgu_xlate.sv
module pgu_xlate #(
   parameter int VA_W  = 18,
   parameter int OFS_W = 10,
   parameter int PA_W  = 22
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_write,
   input  logic                  xlate_en,
   input  logic                  fault_pend,
   input  logic                  map_hit,
   input  logic                  map_wen,
   input  logic [PA_W-OFS_W-1:0] map_ppn,
   output logic                  fault_new,
   output logic                  pa_valid,
   output logic [PA_W-1:0]       pa,
   output logic                  fault
);
   localparam bit TIE_HOLE = (PA_W == 22);

   logic miss, reject;
   logic [PA_W-1:0] pa_raw, pa_next;

   assign miss      = !map_hit || (req_write && !map_wen);
   assign reject    = req_valid && (fault_pend || (xlate_en && miss));
   assign fault_new = req_valid && !fault_pend && xlate_en && miss;
   assign pa_raw    = xlate_en ? {map_ppn, req_va[OFS_W-1:0]} : PA_W'(req_va);

   if (TIE_HOLE) begin : g_hole
      always_comb begin
         pa_next        = pa_raw;
         pa_next[15:14] = 2'b00;
      end
      // R11: bits 15:14 never leave the unit as ones
      always_comb begin
         if (rst_n && pa_valid) a_r11_hole_zero: assert (pa[15:14] == 2'b00);
      end
   end else begin : g_full
      assign pa_next = pa_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_valid <= 1'b0;
         fault    <= 1'b0;
         pa       <= '0;
      end else begin
         pa_valid <= req_valid && !reject;
         fault    <= reject;
         if (req_valid && !reject) pa <= pa_next;
      end
   end

   // R5: an answer is either an address or a fault
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_valid && fault));
   // R7: requests made while a fault is pending are refused
   a_r7_refuse_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fault_pend) |=> (fault && !pa_valid));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
   import pgu_pkg::*;
#(
   parameter int VA_W   = 18,
   parameter int OFS_W  = 10,
   parameter int PA_W   = 20,
   parameter int DATA_W = 36
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_va,
   input  logic                    req_write,
   input  logic                    req_user,
   output logic                    pa_valid,
   output logic [PA_W-1:0]         pa,
   output logic                    fault,
   output logic                    store_inhibit,
   input  logic                    instr_start,
   input  logic [DATA_W-1:0]       pc_flags,
   input  logic                    map_wr,
   input  logic                    map_user,
   input  logic [VA_W-OFS_W-1:0]   map_vpn,
   input  logic                    map_valid,
   input  logic                    map_wen,
   input  logic [PA_W-OFS_W-1:0]   map_ppn,
   input  logic                    blk_load,
   input  logic                    blk_store,
   input  logic [VA_W-1:0]         blk_base,
   output logic                    blk_busy,
   output logic                    blk_rd,
   output logic                    blk_wr,
   output logic [VA_W-1:0]         blk_addr,
   input  logic [DATA_W-1:0]       blk_rdata,
   output logic [DATA_W-1:0]       blk_wdata
);
   localparam int VPN_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;

   if (VA_W <= OFS_W) begin : g_bad_ofs
      $error("VA_W must exceed OFS_W");
   end
   if (PA_W < VA_W) begin : g_bad_pa
      $error("PA_W must be at least VA_W");
   end
   if (DATA_W <= VA_W + 3) begin : g_bad_data
      $error("DATA_W too small for the fault record");
   end
   if (PA_W == 22 && OFS_W > 14) begin : g_bad_hole
      $error("bits 15:14 must lie in the page number");
   end

   logic             lk_hit, lk_wen;
   logic [PPN_W-1:0] lk_ppn;
   logic             en, pend, fault_new;

   pgu_map #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .wr(map_wr), .wr_user(map_user), .wr_vpn(map_vpn),
      .wr_valid(map_valid), .wr_wen(map_wen), .wr_ppn(map_ppn),
      .rd_user(req_user), .rd_vpn(req_va[VA_W-1:OFS_W]),
      .rd_hit(lk_hit), .rd_wen(lk_wen), .rd_ppn(lk_ppn)
   );

   pgu_xlate #(.VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
      .xlate_en(en), .fault_pend(pend),
      .map_hit(lk_hit), .map_wen(lk_wen), .map_ppn(lk_ppn),
      .fault_new(fault_new), .pa_valid(pa_valid), .pa(pa), .fault(fault)
   );

   pgu_regs #(.VA_W(VA_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .blk_load(blk_load), .blk_store(blk_store), .blk_base(blk_base),
      .blk_rdata(blk_rdata), .blk_busy(blk_busy), .blk_rd(blk_rd),
      .blk_wr(blk_wr), .blk_addr(blk_addr), .blk_wdata(blk_wdata),
      .fault_set(fault_new), .fault_write(req_write), .fault_user(req_user),
      .fault_va(req_va), .instr_start(instr_start), .pc_flags(pc_flags),
      .xlate_en(en), .fault_pend(pend)
   );

   assign store_inhibit = pend;

   // R3: the in-page offset crosses the unit unchanged
   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      pa_valid |-> pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0]));
   // R7: a new fault raises store inhibit on the next cycle
   a_r7_inhibit_rises: assert property (@(posedge clk) disable iff (!rst_n)
      fault_new |=> store_inhibit);
endmodule

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb;
   localparam int VA_W = 18, OFS_W = 10, PA_W = 22, DATA_W = 36;
   localparam int VPN_W = VA_W - OFS_W, PPN_W = PA_W - OFS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic req_valid = 0, req_write = 0, req_user = 0;
   logic [VA_W-1:0] req_va = '0;
   logic pa_valid, fault, store_inhibit;
   logic [PA_W-1:0] pa;
   logic instr_start = 0;
   logic [DATA_W-1:0] pc_flags = '0;
   logic map_wr = 0, map_user = 0, map_valid = 0, map_wen = 0;
   logic [VPN_W-1:0] map_vpn = '0;
   logic [PPN_W-1:0] map_ppn = '0;
   logic blk_load = 0, blk_store = 0;
   logic [VA_W-1:0] blk_base = '0;
   logic blk_busy, blk_rd, blk_wr;
   logic [VA_W-1:0] blk_addr;
   logic [DATA_W-1:0] blk_rdata, blk_wdata;

   page_xlate_unit #(.VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .req_user(req_user), .pa_valid(pa_valid), .pa(pa),
      .fault(fault), .store_inhibit(store_inhibit), .instr_start(instr_start),
      .pc_flags(pc_flags), .map_wr(map_wr), .map_user(map_user), .map_vpn(map_vpn),
      .map_valid(map_valid), .map_wen(map_wen), .map_ppn(map_ppn),
      .blk_load(blk_load), .blk_store(blk_store), .blk_base(blk_base),
      .blk_busy(blk_busy), .blk_rd(blk_rd), .blk_wr(blk_wr), .blk_addr(blk_addr),
      .blk_rdata(blk_rdata), .blk_wdata(blk_wdata));

   // memory images: one source for loads, one sink for stores
   logic [DATA_W-1:0] ld_img [512];
   logic [DATA_W-1:0] st_img [512];
   assign blk_rdata = ld_img[blk_addr[8:0]];
   always @(posedge clk) if (blk_wr) st_img[blk_addr[8:0]] <= blk_wdata;

   // reference model state
   logic              m_valid [2][256];
   logic              m_wen   [2][256];
   logic [PPN_W-1:0]  m_ppn   [2][256];
   logic [DATA_W-1:0] m_slot  [8];
   logic              m_pend = 0;

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [PA_W-1:0] exp_pa(logic [VA_W-1:0] va, logic u);
      logic [PA_W-1:0] r;
      if (m_slot[0][0]) r = {m_ppn[u][va[17:10]], va[9:0]};
      else              r = PA_W'(va);
      r[15:14] = 2'b00;
      return r;
   endfunction

   function automatic logic would_fault(logic [VA_W-1:0] va, logic w, logic u);
      return m_slot[0][0] && (!m_valid[u][va[17:10]] || (w && !m_wen[u][va[17:10]]));
   endfunction

   task automatic do_req(logic [VA_W-1:0] va, logic w, logic u, string req);
      logic rej;
      @(negedge clk);
      req_valid = 1; req_va = va; req_write = w; req_user = u;
      rej = m_pend || would_fault(va, w, u);
      @(negedge clk);
      req_valid = 0;
      check(req, {62'd0, pa_valid, fault}, {62'd0, !rej, rej});
      if (!rej) begin
         check(req, 64'(pa), 64'(exp_pa(va, u)));
         check("R11", 64'(pa[15:14]), 64'd0);
      end
      if (!m_pend && rej) begin
         m_pend = 1;
         m_slot[5] = {1'b1, w, u, 15'd0, va};
      end
   endtask

   task automatic map_write(logic u, logic [VPN_W-1:0] v, logic vl, logic we, logic [PPN_W-1:0] p);
      @(negedge clk);
      map_wr = 1; map_user = u; map_vpn = v; map_valid = vl; map_wen = we; map_ppn = p;
      @(negedge clk);
      map_wr = 0;
      m_valid[u][v] = vl; m_wen[u][v] = we; m_ppn[u][v] = p;
   endtask

   task automatic pulse_pc(logic [DATA_W-1:0] v);
      @(negedge clk);
      instr_start = 1; pc_flags = v;
      @(negedge clk);
      instr_start = 0;
      if (!m_pend) m_slot[6] = v;
   endtask

   task automatic run_load(int base, bit poke_store);
      @(negedge clk);
      blk_load = 1; blk_base = VA_W'(base);
      @(negedge clk);
      blk_load = 0;
      for (int i = 0; i < 8; i++) begin
         if (poke_store) blk_store = (i == 2);
         check("R9", {61'd0, blk_busy, blk_rd, blk_wr}, {61'd0, 3'b110});
         check("R9", 64'(blk_addr), 64'(base + i));
         @(negedge clk);
      end
      blk_store = 0;
      check("R12", {62'd0, blk_busy, blk_wr}, 64'd0);
      for (int i = 0; i < 8; i++) begin
         if (i == 5) begin m_slot[5] = '0; m_pend = 0; end
         else if (i != 6) m_slot[i] = ld_img[base + i];
      end
   endtask

   task automatic run_store_check(int base, string req);
      @(negedge clk);
      blk_store = 1; blk_base = VA_W'(base);
      @(negedge clk);
      blk_store = 0;
      for (int i = 0; i < 8; i++) begin
         check("R10", {62'd0, blk_wr, blk_rd}, {62'd0, 2'b10});
         check("R10", 64'(blk_addr), 64'(base + i));
         @(negedge clk);
      end
      check("R10", 64'(blk_busy), 64'd0);
      for (int i = 0; i < 8; i++) check(req, 64'(st_img[base + i]), 64'(m_slot[i]));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [VA_W-1:0] va;
      logic w, u;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 512; i++) begin ld_img[i] = '0; st_img[i] = '0; end
      for (int i = 0; i < 8; i++) m_slot[i] = '0;
      for (int h = 0; h < 2; h++)
         for (int v = 0; v < 256; v++) begin m_valid[h][v] = 0; m_wen[h][v] = 0; m_ppn[h][v] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: idle outputs after reset and all-zero slots
      check("R1", {60'd0, pa_valid, fault, store_inhibit, blk_busy}, 64'd0);
      run_store_check(100, "R1");

      // R2: pass-through while disabled, also R11 on the upper bits
      do_req(18'h3FFFF, 0, 0, "R2");
      do_req(18'h0C3A5, 1, 1, "R2");
      for (int k = 0; k < 8; k++) do_req(VA_W'($urandom()), 1'($urandom()), 1'($urandom()), "R2");

      // fill both halves with mixed patterns
      for (int v = 0; v < 256; v++) begin
         map_write(0, VPN_W'(v), (v % 7) != 3, v[0], PPN_W'($urandom()));
         map_write(1, VPN_W'(v), (v % 5) != 1, v[1], PPN_W'($urandom()));
      end
      // R4: same page, different halves
      map_write(0, 8'd5, 1, 1, 12'h0A5);
      map_write(1, 8'd5, 1, 1, 12'hF3C);

      // R9: load control words, enable translation via slot 0 bit 0
      ld_img[200] = 36'h0_0000_0001;
      for (int i = 1; i < 8; i++) ld_img[200 + i] = {4'($urandom()), 32'($urandom())};
      ld_img[205] = '1;
      pulse_pc(36'h8_0000_1234);
      run_load(200, 1);  // R12: store request during the load
      run_store_check(300, "R9");

      do_req({8'd5, 10'h155}, 0, 0, "R4");
      do_req({8'd5, 10'h155}, 0, 1, "R4");

      // R3: random non-faulting requests
      for (int k = 0; k < 60; k++) begin
         va = VA_W'($urandom()); w = 1'($urandom()); u = 1'($urandom());
         if (would_fault(va, w, u)) w = 0;
         if (!would_fault(va, w, u)) do_req(va, w, u, "R3");
      end

      // R6: read of a read-only page works, write faults
      map_write(0, 8'd20, 1, 0, 12'h123);
      do_req({8'd20, 10'h001}, 0, 0, "R6");
      do_req({8'd20, 10'h002}, 1, 0, "R6");
      check("R7", 64'(store_inhibit), 64'd1);
      // R7: later requests refused, record keeps the first fault
      do_req({8'd5, 10'h000}, 0, 0, "R7");
      pulse_pc(36'h1_2345_6789);   // R8: frozen while pending
      run_store_check(400, "R7");

      // R9: reload clears the fault; R5: a miss in the user half
      pulse_pc(36'h7_7777_0000);
      run_load(200, 0);
      check("R9", 64'(store_inhibit), 64'd0);
      pulse_pc(36'h2_0000_4321);   // R8: capture resumes
      map_write(1, 8'd99, 0, 1, 12'h000);
      do_req({8'd99, 10'h3FF}, 1, 1, "R5");
      run_store_check(420, "R5");
      run_store_check(440, "R8");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule